// File: doc/BRIEF.md
# Programmable Address Aperture Decoder

This block sorts every 32-bit processor address into one of three destinations: the local SDRAM, the memory-mapped register space (MMIO) or the PCI bus. Software moves the SDRAM and MMIO windows through a small register write port. The decode result comes out one clock after the request as a one-hot destination select. It carries the byte offset of the address inside the chosen window.

The SDRAM window runs from a programmable base up to a programmable limit. The base is included and the limit is not. Both are kept at 512 KB granularity. The MMIO window is a fixed 2 MB span, placed at a 2 MB-aligned programmable base. A fixed reserved hole covers the legacy range 0x000A0000 to 0x000FFFFF. When the SDRAM window covers the hole, SDRAM serves it. Otherwise hole addresses go to PCI, like every other address that no window claims.

Top module: `aperture_decoder`

## Requirements
- R1: During and after a synchronous reset, all three selects are low and the offset is 0. The MMIO base reads as 0xEFE00000, and base and limit are both 0, so the SDRAM window is disabled.
- R2: A request with base <= address < limit selects SDRAM, provided no MMIO hit applies.
- R3: A request whose bits [31:21] equal the MMIO base bits [31:21] selects MMIO. This holds even when the address also lies in the SDRAM window.
- R4: A request that hits neither window selects PCI. For each valid request, exactly one select is high.
- R5: A limit that is less than or equal to the base disables the SDRAM window. A window larger than 64 MB is cut to end at base + 64 MB.
- R6: Addresses 0x000A0000 to 0x000FFFFF go to SDRAM when the SDRAM window covers them, and to PCI otherwise.
- R7: The selects and the offset appear on the clock edge after the edge that samples reqValid. A cycle without reqValid gives all selects low and offset 0 one edge later.
- R8: The offset is address minus SDRAM base for an SDRAM hit, and address minus MMIO base for an MMIO hit. For PCI it is the full address.
- R9: cfgIdx selects the register being written: 0 is the SDRAM base, 1 the SDRAM limit, 2 the MMIO base. A write with index 3 has no effect. The base and limit keep only data bits [31:19], and the MMIO base keeps only bits [31:21].
- R10: A register write takes effect only for requests sampled on later edges. A request sampled on the same edge as the write decodes against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Address to classify |
| cfgWe | input | 1 | Register write enable |
| cfgIdx | input | 2 | Register index (0 SDRAM base, 1 SDRAM limit, 2 MMIO base) |
| cfgData | input | 32 | Register write data |
| selSdram | output | 1 | Destination is SDRAM |
| selMmio | output | 1 | Destination is register space |
| selPci | output | 1 | Destination is PCI |
| apOffset | output | 32 | Offset inside the selected aperture |

## Verification
Every decode result is due exactly one edge after the edge that samples its request. A register write changes decoding only for requests sampled from the following edge onward. The reference model in the bench mirrors this. At each rising edge it computes the expected selects and offset from the request that edge samples, using the register values from before that edge. Only then does it apply any write from the same edge. It compares the design's outputs at the following falling edge, so each comparison lands in the cycle where the registered result is stable.

// File: rtl/aperture_pkg.sv
package aperture_pkg;

  localparam int IDX_DRAM_BASE  = 0;
  localparam int IDX_DRAM_LIMIT = 1;
  localparam int IDX_MMIO_BASE  = 2;

  // Load and capture strobes passed from control to datapath
  typedef struct packed {
    logic ldDramBase;
    logic ldDramLimit;
    logic ldMmioBase;
    logic capture;
  } apStrobe_t;

  typedef enum logic [1:0] {
    ROUTE_PCI   = 2'd0,
    ROUTE_SDRAM = 2'd1,
    ROUTE_MMIO  = 2'd2,
    ROUTE_HOLE  = 2'd3
  } route_e;

endpackage

// File: rtl/aperture_ctrl.sv
module aperture_ctrl
  import aperture_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             reqValid,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  output apStrobe_t        strobe
);

  always_comb begin
    strobe             = '0;
    strobe.capture     = reqValid;
    strobe.ldDramBase  = cfgWe && (cfgIdx == IDX_W'(IDX_DRAM_BASE));
    strobe.ldDramLimit = cfgWe && (cfgIdx == IDX_W'(IDX_DRAM_LIMIT));
    strobe.ldMmioBase  = cfgWe && (cfgIdx == IDX_W'(IDX_MMIO_BASE));
  end

endmodule

// File: rtl/aperture_dp.sv
module aperture_dp
  import aperture_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              GRAN_LOG2  = 19,
  parameter int              MMIO_LOG2  = 21,
  parameter int              MAX_UNITS  = 128,
  parameter logic [ADDR_W-1:0] MMIO_RESET = 32'hEFE0_0000,
  parameter logic [ADDR_W-1:0] HOLE_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HOLE_LIMIT = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  apStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] cfgData,
  output logic              selSdram,
  output logic              selMmio,
  output logic              selPci,
  output logic [ADDR_W-1:0] apOffset
);

  localparam int HI_W  = ADDR_W - GRAN_LOG2;
  localparam int MHI_W = ADDR_W - MMIO_LOG2;
  localparam logic [HI_W:0] CAP_UNITS = (HI_W+1)'(MAX_UNITS);

  logic [HI_W-1:0]  dramBaseQ, dramLimitQ;
  logic [MHI_W-1:0] mmioBaseQ;

  // Aperture registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dramBaseQ  <= '0;
      dramLimitQ <= '0;
      mmioBaseQ  <= MMIO_RESET[ADDR_W-1:MMIO_LOG2];
    end else begin
      if (strobe.ldDramBase)  dramBaseQ  <= cfgData[ADDR_W-1:GRAN_LOG2];
      if (strobe.ldDramLimit) dramLimitQ <= cfgData[ADDR_W-1:GRAN_LOG2];
      if (strobe.ldMmioBase)  mmioBaseQ  <= cfgData[ADDR_W-1:MMIO_LOG2];
    end
  end

  // Granule-level window compare
  logic [HI_W:0] baseExt, limExt, capExt, effLimit, addrExt;
  logic          dramEn, dramHit, mmioHit, holeHit;
  route_e        route;
  logic [ADDR_W-1:0] dramBaseAddr, mmioBaseAddr, offsetNext;

  always_comb begin
    baseExt  = {1'b0, dramBaseQ};
    limExt   = {1'b0, dramLimitQ};
    capExt   = baseExt + CAP_UNITS;
    effLimit = (limExt > capExt) ? capExt : limExt;
    addrExt  = {1'b0, reqAddr[ADDR_W-1:GRAN_LOG2]};
    dramEn   = limExt > baseExt;
    dramHit  = dramEn && (addrExt >= baseExt) && (addrExt < effLimit);
    mmioHit  = reqAddr[ADDR_W-1:MMIO_LOG2] == mmioBaseQ;
    holeHit  = (reqAddr >= HOLE_BASE) && (reqAddr < HOLE_LIMIT);
  end

  // Priority: MMIO, then SDRAM (over the hole), then hole, then PCI
  always_comb begin
    if (mmioHit)      route = ROUTE_MMIO;
    else if (dramHit) route = ROUTE_SDRAM;
    else if (holeHit) route = ROUTE_HOLE;
    else              route = ROUTE_PCI;
  end

  always_comb begin
    dramBaseAddr = {dramBaseQ, {GRAN_LOG2{1'b0}}};
    mmioBaseAddr = {mmioBaseQ, {MMIO_LOG2{1'b0}}};
    unique case (route)
      ROUTE_MMIO:  offsetNext = reqAddr - mmioBaseAddr;
      ROUTE_SDRAM: offsetNext = reqAddr - dramBaseAddr;
      default:     offsetNext = reqAddr;
    endcase
  end

  // Registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      selSdram <= 1'b0;
      selMmio  <= 1'b0;
      selPci   <= 1'b0;
      apOffset <= '0;
    end else if (strobe.capture) begin
      selSdram <= route == ROUTE_SDRAM;
      selMmio  <= route == ROUTE_MMIO;
      selPci   <= (route == ROUTE_PCI) || (route == ROUTE_HOLE);
      apOffset <= offsetNext;
    end else begin
      selSdram <= 1'b0;
      selMmio  <= 1'b0;
      selPci   <= 1'b0;
      apOffset <= '0;
    end
  end

endmodule

// File: rtl/aperture_decoder.sv
module aperture_decoder
  import aperture_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 2,
  parameter int GRAN_LOG2 = 19,
  parameter int MMIO_LOG2 = 21,
  parameter int MAX_UNITS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  output logic              selSdram,
  output logic              selMmio,
  output logic              selPci,
  output logic [ADDR_W-1:0] apOffset
);

  apStrobe_t strobe;

  aperture_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .reqValid (reqValid),
    .cfgWe    (cfgWe),
    .cfgIdx   (cfgIdx),
    .strobe   (strobe)
  );

  aperture_dp #(
    .ADDR_W    (ADDR_W),
    .GRAN_LOG2 (GRAN_LOG2),
    .MMIO_LOG2 (MMIO_LOG2),
    .MAX_UNITS (MAX_UNITS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .cfgData  (cfgData),
    .selSdram (selSdram),
    .selMmio  (selMmio),
    .selPci   (selPci),
    .apOffset (apOffset)
  );

endmodule

// File: rtl/aperture_decoder_chk.sv
module aperture_decoder_chk #(
  parameter int ADDR_W    = 32,
  parameter int MMIO_LOG2 = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              selSdram,
  input logic              selMmio,
  input logic              selPci,
  input logic [ADDR_W-1:0] apOffset
);

  assert_onehot_sel_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({selSdram, selMmio, selPci}));

  assert_valid_gives_sel_R7: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> $countones({selSdram, selMmio, selPci}) == 1);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> ({selSdram, selMmio, selPci} == 3'b000) && (apOffset == '0));

  assert_mmio_offset_span_R3: assert property (@(posedge clk) disable iff (rst)
    selMmio |-> (apOffset >> MMIO_LOG2) == '0);

  assert_pci_offset_R8: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> selPci |-> apOffset == $past(reqAddr));

endmodule

bind aperture_decoder aperture_decoder_chk #(.ADDR_W(ADDR_W), .MMIO_LOG2(MMIO_LOG2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .selSdram (selSdram),
  .selMmio  (selMmio),
  .selPci   (selPci),
  .apOffset (apOffset)
);

// File: tb/tb_aperture_decoder.sv
module tb_aperture_decoder;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic        cfgWe;
  logic [1:0]  cfgIdx;
  logic [31:0] cfgData;
  logic        selSdram, selMmio, selPci;
  logic [31:0] apOffset;

  always #2 clk = ~clk;

  aperture_decoder dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .selSdram(selSdram), .selMmio(selMmio), .selPci(selPci), .apOffset(apOffset)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  bit    started = 0;
  bit    done = 0;
  string phase = "R1";

  // Behavioural reference state
  longint unsigned mBase, mLim, mMmio, a, cap, eff;
  bit    expS, expM, expP, dramIn, mmIn, holeIn;
  logic [31:0] expOff;
  string expTag;

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (rst) begin
      mBase = 0; mLim = 0; mMmio = 64'hEFE0_0000;
      expS = 0; expM = 0; expP = 0; expOff = 0; expTag = "R1";
    end else begin
      if (reqValid) begin
        a      = reqAddr;
        cap    = mBase + 64'h0400_0000;
        eff    = (mLim < cap) ? mLim : cap;
        dramIn = (mLim > mBase) && (a >= mBase) && (a < eff);
        mmIn   = (a & 64'hFFE0_0000) == mMmio;
        holeIn = (a >= 64'h000A_0000) && (a < 64'h0010_0000);
        expS = 0; expM = 0; expP = 0;
        if (mmIn) begin
          expM = 1; expOff = 32'(a - mMmio); expTag = "R3";
        end else if (dramIn) begin
          expS = 1; expOff = 32'(a - mBase); expTag = holeIn ? "R6" : "R2";
        end else begin
          expP = 1; expOff = 32'(a); expTag = holeIn ? "R6" : "R4";
        end
      end else begin
        expS = 0; expM = 0; expP = 0; expOff = 0; expTag = "R7";
      end
      if (cfgWe) begin
        case (cfgIdx)
          2'd0: mBase = cfgData & 32'hFFF8_0000;
          2'd1: mLim  = cfgData & 32'hFFF8_0000;
          2'd2: mMmio = cfgData & 32'hFFE0_0000;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if ({selSdram, selMmio, selPci} !== {expS, expM, expP} || apOffset !== expOff) begin
        miscompares++;
        $display("FAIL %s/%s: got sel(s,m,p)=%b%b%b off=%h, expected %b%b%b off=%h",
                 phase, expTag, selSdram, selMmio, selPci, apOffset, expS, expM, expP, expOff);
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      finishRun();
    end
  end

  task automatic idle();
    @(negedge clk);
    reqValid = 0; cfgWe = 0;
  endtask

  task automatic req(input logic [31:0] addr);
    @(negedge clk);
    reqValid = 1; reqAddr = addr; cfgWe = 0;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    reqValid = 0; cfgWe = 1; cfgIdx = idx; cfgData = data;
  endtask

  task automatic reqWr(input logic [31:0] addr, input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    reqValid = 1; reqAddr = addr; cfgWe = 1; cfgIdx = idx; cfgData = data;
  endtask

  logic [31:0] rnd;

  initial begin
    rst = 1; reqValid = 0; reqAddr = 0; cfgWe = 0; cfgIdx = 0; cfgData = 0;
    repeat (3) idle();
    @(negedge clk); rst = 0;
    // R1: reset MMIO base, SDRAM disabled
    phase = "R1";
    req(32'hEFE0_0000); req(32'hEFFF_FFFF); req(32'hEFDF_FFFF); req(32'h0000_0000);
    idle();
    // R2: half-open SDRAM window, R8 offsets
    phase = "R2";
    wr(0, 32'h0000_0000); wr(1, 32'h0200_0000);
    req(32'h01FF_FFFF); req(32'h0200_0000); req(32'h0000_0000);
    // R6: hole covered by SDRAM, then uncovered
    phase = "R6";
    req(32'h000A_0000); req(32'h000F_FFFF);
    wr(0, 32'h0040_0000);
    req(32'h000B_0000); req(32'h0040_0000); req(32'h0009_FFFF);
    // R5: 64 MB cap and disable when limit <= base
    phase = "R5";
    wr(0, 32'h1000_0000); wr(1, 32'h2000_0000);
    req(32'h13FF_FFFF); req(32'h1400_0000);
    wr(1, 32'h1000_0000); req(32'h1000_0000);
    wr(1, 32'h0F00_0000); req(32'h1000_0000);
    // R9: register index map, low bits dropped, index 3 ignored
    phase = "R9";
    wr(0, 32'h3007_FFFF); wr(1, 32'h3010_0001);
    req(32'h3000_0000); req(32'h300F_FFFF); req(32'h3010_0000);
    wr(3, 32'hFFFF_FFFF); req(32'h3000_0000); req(32'hEFE0_0004);
    // R3: MMIO overrides an overlapping SDRAM window
    phase = "R3";
    wr(2, 32'h301F_FFFF); req(32'h3000_0010); req(32'hEFE0_0004);
    // R10: same-edge write uses old value, next request sees new one
    phase = "R10";
    reqWr(32'h3000_0010, 2, 32'hEFE0_0000); req(32'h3000_0010);
    idle();
    // R8: mixed traffic with live reprogramming
    phase = "R8";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rnd      = $urandom;
      cfgWe    = (rnd[3:0] == 4'd0);
      cfgIdx   = rnd[5:4];
      cfgData  = rnd[10] ? (32'h3000_0000 | ($urandom & 32'h07FF_FFFF)) : $urandom;
      reqValid = rnd[6] | rnd[7];
      case (rnd[9:8])
        2'd0: reqAddr = 32'h3000_0000 | ($urandom & 32'h0FFF_FFFF);
        2'd1: reqAddr = 32'h000A_0000 + ($urandom & 32'h0007_FFFF);
        2'd2: reqAddr = $urandom;
        default: reqAddr = 32'h3000_0000 | ($urandom & 32'h003F_FFFF);
      endcase
    end
    repeat (3) idle();
    @(posedge clk);
    @(negedge clk);
    #1;
    finishRun();
  end

endmodule